// File: doc/BRIEF.md
# Memory-Mapped GPIO Register Block

This block is a 32-bit general-purpose I/O register file on a simple synchronous word bus. It holds the level driven on each pin, a per-pin direction mask and one spare read/write word. Software changes pin levels through two write-only strobes. One strobe raises the bits given in the write data and the other lowers them. Either strobe takes effect only when the written mask reaches at least one pin configured as an output. When it does, the whole mask is applied, including bits of input pins. When it does not, the write is discarded and a one-cycle error pulse is raised.

The bus has no handshake. A write is sampled on the clock edge where `bus_wr` is high and lands on that edge. A read strobe is answered by registered data in the following cycle. Three offsets reserved for edge control accept writes and change nothing. Any other access outside the map also changes nothing, but it raises the error pulse. Nine interrupt outputs exist for wiring compatibility and are held low permanently. The level and direction registers drive the pin outputs directly.

Register offsets (byte addresses, word aligned): level 0x00 (read only), direction 0x04, raise-strobe 0x08, lower-strobe 0x0C, edge-control 0x10/0x14/0x18 (write sink), spare word 0x20.

Top module: `gpio_regblock`

## Requirements
- R1: After reset, `pin_level`, `pin_dir`, the spare word and `bus_rdata` are all zero, and `acc_err` is low.
- R2: A write to 0x04 loads `pin_dir` on the sampling edge, and a read of 0x04 returns it.
- R3: A write to 0x08 whose data shares at least one set bit with `pin_dir` ORs the full write data into `pin_level` on the sampling edge.
- R4: A write to 0x0C whose data shares at least one set bit with `pin_dir` clears every `pin_level` bit that is set in the write data, on the sampling edge.
- R5: A write to 0x08 or 0x0C whose data has no set bit in common with `pin_dir` leaves `pin_level` unchanged and raises `acc_err` in the following cycle.
- R6: The spare word at 0x20 is read/write and is independent of `pin_level` and `pin_dir`.
- R7: Writes to 0x10, 0x14 and 0x18 change no register and do not raise `acc_err`.
- R8: A read of any offset other than 0x00, 0x04 and 0x20 returns zero. A write to any offset other than 0x04, 0x08, 0x0C, 0x10, 0x14, 0x18 and 0x20 changes nothing. In both cases, and for every address whose two low bits are not zero, `acc_err` is raised in the following cycle.
- R9: `bus_rdata` carries the addressed value in the cycle after `bus_rd` is high and is zero in any cycle that does not follow a read strobe.
- R10: All nine bits of `irq_out` are zero at all times.
- R11: `acc_err` is a single-cycle pulse per offending access and is low after any cycle with no bus strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W (8) | Byte address of the access |
| bus_wr | input | 1 | Write strobe, sampled on the rising edge |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Read data, valid the cycle after the read strobe |
| pin_level | output | 32 | Level driven for each pin |
| pin_dir | output | 32 | Direction per pin, 1 = output |
| irq_out | output | 9 | Eight per-pin lines and one combined line, always low |
| acc_err | output | 1 | One-cycle pulse for a discarded or undefined access |

## Verification
Every result is due exactly one clock edge after the strobe that causes it. Register contents, `pin_level`, `pin_dir` and `acc_err` all change on the edge that samples the write, and `bus_rdata` is registered on the edge that samples the read. The bench drives strobes on the falling edge and holds them for one cycle. It then samples on the next falling edge, half a period after the edge that produced the result. One further falling edge later, it checks that `acc_err` and `bus_rdata` have returned to zero.

// File: rtl/gpio_rb_pkg.sv
package gpio_rb_pkg;

  localparam int DATA_W = 32;

  // Byte offsets of the map (word aligned)
  localparam logic [7:0] OFF_LEVEL = 8'h00;
  localparam logic [7:0] OFF_DIR   = 8'h04;
  localparam logic [7:0] OFF_RAISE = 8'h08;
  localparam logic [7:0] OFF_LOWER = 8'h0C;
  localparam logic [7:0] OFF_EDGE0 = 8'h10;
  localparam logic [7:0] OFF_EDGE1 = 8'h14;
  localparam logic [7:0] OFF_EDGE2 = 8'h18;
  localparam logic [7:0] OFF_SPARE = 8'h20;

  typedef enum logic [2:0] {
    SEL_LEVEL,
    SEL_DIR,
    SEL_RAISE,
    SEL_LOWER,
    SEL_EDGE,
    SEL_SPARE,
    SEL_NONE
  } reg_sel_e;

endpackage

// File: rtl/gpio_rb_decode.sv
module gpio_rb_decode
  import gpio_rb_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr,
  input  logic              rd,
  output reg_sel_e          sel,
  output logic              wr_bad,
  output logic              rd_bad
);

  logic aligned;
  assign aligned = (addr[1:0] == 2'b00);

  always_comb begin
    sel = SEL_NONE;
    if (aligned) begin
      if      (addr == ADDR_W'(OFF_LEVEL)) sel = SEL_LEVEL;
      else if (addr == ADDR_W'(OFF_DIR))   sel = SEL_DIR;
      else if (addr == ADDR_W'(OFF_RAISE)) sel = SEL_RAISE;
      else if (addr == ADDR_W'(OFF_LOWER)) sel = SEL_LOWER;
      else if (addr == ADDR_W'(OFF_EDGE0) ||
               addr == ADDR_W'(OFF_EDGE1) ||
               addr == ADDR_W'(OFF_EDGE2)) sel = SEL_EDGE;
      else if (addr == ADDR_W'(OFF_SPARE)) sel = SEL_SPARE;
    end
  end

  // Readable: level, direction, spare. Writable: all but level and unmapped.
  always_comb begin
    rd_bad = 1'b0;
    wr_bad = 1'b0;
    if (rd) begin
      rd_bad = !(sel == SEL_LEVEL || sel == SEL_DIR || sel == SEL_SPARE);
    end
    if (wr) begin
      wr_bad = (sel == SEL_LEVEL || sel == SEL_NONE);
    end
  end

endmodule

// File: rtl/gpio_rb_regs.sv
module gpio_rb_regs
  import gpio_rb_pkg::*;
#(
  parameter int W = DATA_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr,
  input  reg_sel_e     sel,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] level_q,
  output logic [W-1:0] dir_q,
  output logic [W-1:0] spare_q,
  output logic         strobe_drop
);

  logic         is_strobe;
  logic         overlap;
  logic [W-1:0] level_d;

  assign is_strobe   = wr && (sel == SEL_RAISE || sel == SEL_LOWER);
  assign overlap     = |(wdata & dir_q);
  assign strobe_drop = is_strobe && !overlap;

  always_comb begin
    level_d = level_q;
    if (is_strobe && overlap) begin
      if (sel == SEL_RAISE) level_d = level_q | wdata;
      else                  level_d = level_q & ~wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      level_q <= '0;
      dir_q   <= '0;
      spare_q <= '0;
    end else begin
      level_q <= level_d;
      if (wr && sel == SEL_DIR)   dir_q   <= wdata;
      if (wr && sel == SEL_SPARE) spare_q <= wdata;
    end
  end

endmodule

// File: rtl/gpio_rb_rdmux.sv
module gpio_rb_rdmux
  import gpio_rb_pkg::*;
#(
  parameter int W = DATA_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         rd,
  input  reg_sel_e     sel,
  input  logic [W-1:0] level_q,
  input  logic [W-1:0] dir_q,
  input  logic [W-1:0] spare_q,
  output logic [W-1:0] rdata
);

  logic [W-1:0] rdata_d;

  always_comb begin
    rdata_d = '0;
    if (rd) begin
      unique case (sel)
        SEL_LEVEL: rdata_d = level_q;
        SEL_DIR:   rdata_d = dir_q;
        SEL_SPARE: rdata_d = spare_q;
        default:   rdata_d = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdata <= '0;
    else        rdata <= rdata_d;
  end

endmodule

// File: rtl/gpio_regblock.sv
module gpio_regblock
  import gpio_rb_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int N_LOW_IRQ = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic                 bus_wr,
  input  logic [DATA_W-1:0]    bus_wdata,
  input  logic                 bus_rd,
  output logic [DATA_W-1:0]    bus_rdata,
  output logic [DATA_W-1:0]    pin_level,
  output logic [DATA_W-1:0]    pin_dir,
  output logic [N_LOW_IRQ:0]   irq_out,
  output logic                 acc_err
);

  localparam int N_IRQ = N_LOW_IRQ + 1;

  reg_sel_e          sel;
  logic              wr_bad, rd_bad, strobe_drop;
  logic [DATA_W-1:0] spare_q;

  gpio_rb_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr   (bus_addr),
    .wr     (bus_wr),
    .rd     (bus_rd),
    .sel    (sel),
    .wr_bad (wr_bad),
    .rd_bad (rd_bad)
  );

  gpio_rb_regs #(.W(DATA_W)) u_regs (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr          (bus_wr),
    .sel         (sel),
    .wdata       (bus_wdata),
    .level_q     (pin_level),
    .dir_q       (pin_dir),
    .spare_q     (spare_q),
    .strobe_drop (strobe_drop)
  );

  gpio_rb_rdmux #(.W(DATA_W)) u_rd (
    .clk     (clk),
    .rst_n   (rst_n),
    .rd      (bus_rd),
    .sel     (sel),
    .level_q (pin_level),
    .dir_q   (pin_dir),
    .spare_q (spare_q),
    .rdata   (bus_rdata)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) acc_err <= 1'b0;
    else        acc_err <= wr_bad || rd_bad || strobe_drop;
  end

  // Interrupt lines are present for wiring only and never driven active.
  for (genvar i = 0; i < N_IRQ; i++) begin : g_irq
    assign irq_out[i] = 1'b0;
  end

endmodule

// File: rtl/gpio_regblock_chk.sv
module gpio_regblock_chk #(
  parameter int ADDR_W    = 8,
  parameter int N_LOW_IRQ = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_wr,
  input logic [31:0]       bus_wdata,
  input logic              bus_rd,
  input logic [31:0]       bus_rdata,
  input logic [31:0]       pin_level,
  input logic [31:0]       pin_dir,
  input logic [N_LOW_IRQ:0] irq_out,
  input logic              acc_err
);

  logic w_dir, w_raise, w_lower, w_edge;
  assign w_dir   = bus_wr && bus_addr == ADDR_W'(8'h04);
  assign w_raise = bus_wr && bus_addr == ADDR_W'(8'h08);
  assign w_lower = bus_wr && bus_addr == ADDR_W'(8'h0C);
  assign w_edge  = bus_wr && (bus_addr == ADDR_W'(8'h10) ||
                              bus_addr == ADDR_W'(8'h14) ||
                              bus_addr == ADDR_W'(8'h18));

  p_dir_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    w_dir |=> pin_dir == $past(bus_wdata));

  p_raise_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (w_raise && (bus_wdata & pin_dir) != 32'd0) |=>
      pin_level == ($past(pin_level) | $past(bus_wdata)));

  p_lower_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (w_lower && (bus_wdata & pin_dir) != 32'd0) |=>
      pin_level == ($past(pin_level) & ~$past(bus_wdata)));

  p_drop_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ((w_raise || w_lower) && (bus_wdata & pin_dir) == 32'd0) |=>
      ($stable(pin_level) && acc_err));

  p_edge_sink_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (w_edge && !bus_rd) |=> ($stable(pin_level) && $stable(pin_dir) && !acc_err));

  p_rdata_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |=> bus_rdata == 32'd0);

  p_irq_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out == '0);

  p_err_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_wr && !bus_rd) |=> !acc_err);

endmodule

bind gpio_regblock gpio_regblock_chk #(.ADDR_W(ADDR_W), .N_LOW_IRQ(N_LOW_IRQ)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_addr  (bus_addr),
  .bus_wr    (bus_wr),
  .bus_wdata (bus_wdata),
  .bus_rd    (bus_rd),
  .bus_rdata (bus_rdata),
  .pin_level (pin_level),
  .pin_dir   (pin_dir),
  .irq_out   (irq_out),
  .acc_err   (acc_err)
);

// File: tb/gpio_regblock_tb.sv
module gpio_regblock_tb;

  localparam time CLK_PERIOD = 10ns;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic        bus_rd = 1'b0;
  logic [31:0] bus_rdata, pin_level, pin_dir;
  logic [8:0]  irq_out;
  logic        acc_err;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_regblock u_dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
    .pin_level(pin_level), .pin_dir(pin_dir), .irq_out(irq_out),
    .acc_err(acc_err)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  // Write: strobe for one cycle, return sampled err half a period after the edge.
  task automatic bus_write(logic [7:0] a, logic [31:0] d, output logic err);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
    err = acc_err;
  endtask

  task automatic bus_read(logic [7:0] a, output logic [31:0] d, output logic err);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
    err = acc_err;
  endtask

  task automatic idle_after(string tag);
    @(negedge clk);
    check({tag, " R11 err back low"}, {31'd0, acc_err}, 32'd0);
    check({tag, " R9 rdata idle zero"}, bus_rdata, 32'd0);
  endtask

  task automatic t_reset();
    logic [31:0] d; logic e;
    check("R1 level", pin_level, 32'd0);
    check("R1 dir", pin_dir, 32'd0);
    check("R1 rdata", bus_rdata, 32'd0);
    check("R1 err", {31'd0, acc_err}, 32'd0);
    check("R10 irq", {23'd0, irq_out}, 32'd0);
    bus_read(8'h20, d, e);
    check("R1 spare", d, 32'd0);
  endtask

  task automatic t_dir();
    logic [31:0] d; logic e;
    bus_write(8'h04, 32'h0000_FF0F, e);
    check("R2 pin_dir", pin_dir, 32'h0000_FF0F);
    check("R2 no err", {31'd0, e}, 32'd0);
    bus_read(8'h04, d, e);
    check("R2 readback", d, 32'h0000_FF0F);
    idle_after("R2");
  endtask

  task automatic t_raise();
    logic e;
    bus_write(8'h08, 32'h0000_0F01, e);
    check("R3 whole mask", pin_level, 32'h0000_0F01);
    check("R3 no err", {31'd0, e}, 32'd0);
  endtask

  task automatic t_lower();
    logic [31:0] d; logic e;
    bus_write(8'h0C, 32'h0000_0101, e);
    check("R4 level", pin_level, 32'h0000_0E00);
    bus_read(8'h00, d, e);
    check("R4 readback", d, 32'h0000_0E00);
  endtask

  task automatic t_drop();
    logic e;
    bus_write(8'h08, 32'hF000_0000, e);
    check("R5 raise dropped", pin_level, 32'h0000_0E00);
    check("R5 raise err", {31'd0, e}, 32'd1);
    idle_after("R5");
    bus_write(8'h0C, 32'h0000_0E00 & 32'h0000_00F0 | 32'h0000_00F0, e);
    check("R5 lower dropped", pin_level, 32'h0000_0E00);
    check("R5 lower err", {31'd0, e}, 32'd1);
    idle_after("R5b");
  endtask

  task automatic t_spare();
    logic [31:0] d; logic e;
    bus_write(8'h20, 32'hA5A5_5A5A, e);
    bus_read(8'h20, d, e);
    check("R6 spare", d, 32'hA5A5_5A5A);
    check("R6 level kept", pin_level, 32'h0000_0E00);
    check("R6 dir kept", pin_dir, 32'h0000_FF0F);
  endtask

  task automatic t_edge();
    logic [31:0] d; logic e;
    for (int i = 0; i < 3; i++) begin
      bus_write(8'h10 + 8'(4*i), 32'hFFFF_FFFF, e);
      check("R7 no err", {31'd0, e}, 32'd0);
    end
    check("R7 level", pin_level, 32'h0000_0E00);
    check("R7 dir", pin_dir, 32'h0000_FF0F);
    bus_read(8'h20, d, e);
    check("R7 spare", d, 32'hA5A5_5A5A);
  endtask

  task automatic t_undef();
    logic [31:0] d; logic e;
    bus_read(8'h08, d, e);
    check("R8 read strobe offs zero", d, 32'd0);
    check("R8 read strobe offs err", {31'd0, e}, 32'd1);
    bus_read(8'h1C, d, e);
    check("R8 read hole zero", d, 32'd0);
    check("R8 read hole err", {31'd0, e}, 32'd1);
    bus_write(8'h00, 32'hFFFF_FFFF, e);
    check("R8 level write ignored", pin_level, 32'h0000_0E00);
    check("R8 level write err", {31'd0, e}, 32'd1);
    bus_write(8'h06, 32'h1234_5678, e);
    check("R8 misaligned dir kept", pin_dir, 32'h0000_FF0F);
    check("R8 misaligned err", {31'd0, e}, 32'd1);
    bus_write(8'h40, 32'h1234_5678, e);
    check("R8 far err", {31'd0, e}, 32'd1);
    bus_read(8'h20, d, e);
    check("R8 spare kept", d, 32'hA5A5_5A5A);
    idle_after("R8");
  endtask

  task automatic t_rd_timing();
    @(negedge clk);
    bus_addr = 8'h04; bus_rd = 1'b1;
    @(posedge clk); #1;
    check("R9 data one cycle later", bus_rdata, 32'h0000_FF0F);
    @(negedge clk);
    bus_rd = 1'b0;
    @(negedge clk);
    check("R9 zero after strobe", bus_rdata, 32'd0);
    check("R10 irq", {23'd0, irq_out}, 32'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_dir();
    t_raise();
    t_lower();
    t_drop();
    t_spare();
    t_edge();
    t_undef();
    t_rd_timing();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule